// File: doc/BRIEF.md
# Status Register Write-Protection Controller

This block owns the status byte of a serial flash device and rules on every command that would modify the device. A command decoder presents one request per cycle. The requests are write-enable, write-disable, status write (with a data byte), page program, sector erase (each with a byte address) and bulk erase. The block answers each modifying request, one cycle later, with a single-cycle grant or reject pulse. It also keeps the status byte current.

Protection works at two levels. The two zone bits mark a quarter, a half or all of the array as read-only, counted from the top address down. A lock bit in the status byte works together with the active-low write-protect pin. When the lock bit is set and the pin is low, the status byte is frozen. A granted operation marks the device busy until the array sequencer reports completion on a done input.

Top module: `srwp_ctrl`

## Requirements
- R1: After reset the status byte reads 00h and neither grant nor reject is asserted.
- R2: Status layout: bit 0 is busy, bit 1 is the enable latch, bits 3:2 are the zone bits, bit 7 is the lock bit, and bits 6:4 read 0. A granted status write loads bits 7, 3 and 2 from the data byte and leaves the other bits as they are.
- R3: A write-enable request sets the enable latch. A write-disable request clears it. Neither request pulses grant or reject.
- R4: A modifying request (status write, program, sector erase, bulk erase) made while the enable latch is clear is rejected and changes no protection bit.
- R5: While busy is set, every modifying request is rejected. A done pulse clears busy.
- R6: The enable latch is clear after every modifying request, whether it was granted or rejected.
- R7: With the lock bit at 0, a status write with the latch set is granted at either pin level.
- R8: With the lock bit at 1, a status write is granted if the pin is high and rejected if the pin is low, and then no bit changes. This frozen state is reached by setting the lock bit with the pin low or by lowering the pin after setting the bit. Only raising the pin leaves it.
- R9: The sector is address bits 16:15, so sector k starts at k×8000h. Zone 00 protects no sector, 01 protects sector 3 (18000h–1FFFFh), 10 protects sectors 2–3 and 11 protects all sectors. A program or sector erase aimed at a protected sector is rejected, and one aimed elsewhere is granted.
- R10: A bulk erase is granted only when both zone bits are 0.
- R11: A grant or reject pulse appears in the cycle after the request, never both at once, and a grant leaves busy set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_wren | input | 1 | Write-enable request |
| req_wrdi | input | 1 | Write-disable request |
| req_wrsr | input | 1 | Status write request |
| req_prog | input | 1 | Page program request |
| req_serase | input | 1 | Sector erase request |
| req_berase | input | 1 | Bulk erase request |
| req_addr | input | ADDR_W | Target byte address for program and sector erase |
| sr_wdata | input | 8 | Data byte for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| op_done | input | 1 | Array operation finished, clears busy |
| op_grant | output | 1 | Request granted, one-cycle pulse |
| op_reject | output | 1 | Request refused, one-cycle pulse |
| status | output | 8 | Current status byte |

## Verification
The bench builds the block with ADDR_W = 17 and SECTORS = 4, which gives 32 KiB sectors. Because the sector field is only two bits wide, random addresses reach every zone boundary often. Directed calls also hit 17FFFh/18000h, 0FFFFh/10000h and both ends of the array under each zone code. With these sizes, a few thousand random requests that mix pin toggles, status writes and done pulses visit every combination of the lock bit, the pin level, the zone code and the busy state.

// File: rtl/srwp_pkg.sv
package srwp_pkg;
  localparam int SR_BUSY  = 0;
  localparam int SR_LATCH = 1;
  localparam int SR_LOCK  = 7;
  localparam logic [7:0] SR_WMASK = 8'b1000_1100;

  typedef enum logic [2:0] {
    MC_NONE   = 3'd0,
    MC_WRSR   = 3'd1,
    MC_PROG   = 3'd2,
    MC_SERASE = 3'd3,
    MC_BERASE = 3'd4
  } mod_cmd_e;
endpackage

// File: rtl/srwp_rst_sync.sv
module srwp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/srwp_zone.sv
module srwp_zone #(
  parameter int ADDR_W  = 17,
  parameter int SECTORS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        zone,
  output logic              hit
);
  localparam int SEC_W = $clog2(SECTORS);

  logic [SEC_W-1:0]   sec;
  logic [SECTORS-1:0] locked;
  int unsigned        n_locked;

  assign sec = SEC_W'(addr >> (ADDR_W - SEC_W));

  always_comb begin
    case (zone)
      2'b00:   n_locked = 0;
      2'b01:   n_locked = SECTORS / 4;
      2'b10:   n_locked = SECTORS / 2;
      default: n_locked = SECTORS;
    endcase
  end

  for (genvar k = 0; k < SECTORS; k++) begin : g_sec
    assign locked[k] = (k >= SECTORS - n_locked);
  end

  assign hit = locked[sec];
endmodule

// File: rtl/srwp_gate.sv
module srwp_gate
  import srwp_pkg::*;
(
  input  mod_cmd_e   cmd,
  input  logic       busy,
  input  logic       latch,
  input  logic       lock,
  input  logic [1:0] zone,
  input  logic       wp_n,
  input  logic       zone_hit,
  output logic       grant,
  output logic       reject
);
  logic ok;

  always_comb begin
    ok = 1'b0;
    case (cmd)
      MC_WRSR:            ok = !(lock && !wp_n);
      MC_PROG, MC_SERASE: ok = !zone_hit;
      MC_BERASE:          ok = (zone == 2'b00);
      default:            ok = 1'b0;
    endcase
    if (busy || !latch) ok = 1'b0;
    grant  = (cmd != MC_NONE) && ok;
    reject = (cmd != MC_NONE) && !ok;
  end
endmodule

// File: rtl/srwp_ctrl.sv
module srwp_ctrl
  import srwp_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int SECTORS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_wren,
  input  logic              req_wrdi,
  input  logic              req_wrsr,
  input  logic              req_prog,
  input  logic              req_serase,
  input  logic              req_berase,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        sr_wdata,
  input  logic              wp_n,
  input  logic              op_done,
  output logic              op_grant,
  output logic              op_reject,
  output logic [7:0]        status
);
  logic       rst_n_s;
  logic [7:0] sr_q, sr_d;
  logic       sr_en;
  logic       grant_q, reject_q;
  logic       g_grant, g_reject, zone_hit;
  mod_cmd_e   cmd;

  srwp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  srwp_zone #(.ADDR_W(ADDR_W), .SECTORS(SECTORS)) u_zone (
    .addr(req_addr), .zone(sr_q[3:2]), .hit(zone_hit)
  );

  // one modifying command per cycle; fixed priority if several arrive
  always_comb begin
    if      (req_wrsr)   cmd = MC_WRSR;
    else if (req_prog)   cmd = MC_PROG;
    else if (req_serase) cmd = MC_SERASE;
    else if (req_berase) cmd = MC_BERASE;
    else                 cmd = MC_NONE;
  end

  srwp_gate u_gate (
    .cmd(cmd), .busy(sr_q[SR_BUSY]), .latch(sr_q[SR_LATCH]),
    .lock(sr_q[SR_LOCK]), .zone(sr_q[3:2]), .wp_n(wp_n),
    .zone_hit(zone_hit), .grant(g_grant), .reject(g_reject)
  );

  always_comb begin
    sr_d = sr_q;
    if (req_wren) sr_d[SR_LATCH] = 1'b1;
    if (req_wrdi) sr_d[SR_LATCH] = 1'b0;
    if (op_done)  sr_d[SR_BUSY]  = 1'b0;
    if (cmd != MC_NONE) begin
      sr_d[SR_LATCH] = 1'b0;
      if (g_grant) begin
        sr_d[SR_BUSY] = 1'b1;
        if (cmd == MC_WRSR) sr_d = (sr_d & ~SR_WMASK) | (sr_wdata & SR_WMASK);
      end
    end
  end

  assign sr_en = req_wren | req_wrdi | op_done | (cmd != MC_NONE);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sr_q     <= 8'h00;
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      if (sr_en) sr_q <= sr_d;
      grant_q  <= g_grant;
      reject_q <= g_reject;
    end
  end

  assign status    = sr_q;
  assign op_grant  = grant_q;
  assign op_reject = reject_q;

  // R11: answers are exclusive; a grant leaves busy set
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(op_grant && op_reject));
  a_r11_grant_busy: assert property (@(posedge clk) disable iff (!rst_n_s)
    op_grant |-> status[SR_BUSY]);
  // R5: busy refuses modifying requests
  a_r5_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n_s)
    (status[SR_BUSY] && (cmd != MC_NONE)) |=> op_reject);
  // R6: latch is clear after any modifying request
  a_r6_latch_clear: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd != MC_NONE) |=> !status[SR_LATCH]);
  // R8: frozen status byte keeps lock and zone bits
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n_s)
    (status[SR_LOCK] && !wp_n && cmd == MC_WRSR) |=> ($stable(status[7:2]) && op_reject));
  // R10: bulk erase refused with any zone bit set
  a_r10_bulk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd == MC_BERASE && status[3:2] != 2'b00) |=> op_reject);
  // R4: no latch, no change to protection bits
  a_r4_no_latch: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((cmd != MC_NONE) && !status[SR_LATCH]) |=> (op_reject && $stable(status[7:2])));
  // R2: unused bits stay zero
  a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    status[6:4] == 3'b000);
endmodule

// File: tb/srwp_ctrl_test.sv
`timescale 1ns/1ps
module srwp_ctrl_test;
  localparam int ADDR_W = 17;
  localparam int WATCHDOG_CYC = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_wren = 0, req_wrdi = 0, req_wrsr = 0, req_prog = 0;
  logic req_serase = 0, req_berase = 0, wp_n = 1, op_done = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [7:0] sr_wdata = '0;
  logic op_grant, op_reject;
  logic [7:0] status;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // model state
  bit m_busy = 0, m_latch = 0, m_lock = 0;
  bit [1:0] m_zone = 0;

  always #2.5 clk = ~clk;

  srwp_ctrl #(.ADDR_W(ADDR_W), .SECTORS(4)) uut (
    .clk(clk), .rst_n(rst_n), .req_wren(req_wren), .req_wrdi(req_wrdi),
    .req_wrsr(req_wrsr), .req_prog(req_prog), .req_serase(req_serase),
    .req_berase(req_berase), .req_addr(req_addr), .sr_wdata(sr_wdata),
    .wp_n(wp_n), .op_done(op_done), .op_grant(op_grant),
    .op_reject(op_reject), .status(status)
  );

  function automatic bit in_zone(bit [1:0] z, bit [16:0] a);
    bit [1:0] s = a[16:15];
    case (z)
      2'b00:   return 0;
      2'b01:   return s == 2'd3;
      2'b10:   return s >= 2'd2;
      default: return 1;
    endcase
  endfunction

  function automatic bit [7:0] exp_status();
    return {m_lock, 3'b000, m_zone, m_latch, m_busy};
  endfunction

  // kinds: 0 idle 1 wren 2 wrdi 3 wrsr 4 prog 5 serase 6 berase 7 done
  task automatic issue(input int kind, input bit [16:0] a, input bit [7:0] d,
                       input bit pin, input string tag);
    bit eg = 0, er = 0, ok;
    bit [7:0] es;
    @(negedge clk);
    wp_n = pin; req_addr = a; sr_wdata = d;
    req_wren = (kind == 1); req_wrdi = (kind == 2); req_wrsr = (kind == 3);
    req_prog = (kind == 4); req_serase = (kind == 5); req_berase = (kind == 6);
    op_done = (kind == 7);
    if (kind == 1) m_latch = 1;
    if (kind == 2) m_latch = 0;
    if (kind == 7) m_busy = 0;
    if (kind >= 3 && kind <= 6) begin
      case (kind)
        3:       ok = !(m_lock && !pin);
        4, 5:    ok = !in_zone(m_zone, a);
        default: ok = (m_zone == 0);
      endcase
      if (m_busy || !m_latch) ok = 0;
      eg = ok; er = !ok;
      m_latch = 0;
      if (ok) begin
        m_busy = 1;
        if (kind == 3) begin m_lock = d[7]; m_zone = d[3:2]; end
      end
    end
    es = exp_status();
    @(posedge clk); #1;
    checks++;
    if (op_grant !== eg || op_reject !== er || status !== es) begin
      fails++;
      $display("FAIL %s kind=%0d addr=%h: grant/reject/status = %b/%b/%h, expected %b/%b/%h",
               tag, kind, a, op_grant, op_reject, status, eg, er, es);
    end
    req_wren = 0; req_wrdi = 0; req_wrsr = 0; req_prog = 0;
    req_serase = 0; req_berase = 0; op_done = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    summary();
  end

  initial begin
    int r;
    bit pin;
    bit [16:0] a;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk); #1;
    checks++;
    if (status !== 8'h00 || op_grant !== 0 || op_reject !== 0) begin
      fails++;
      $display("FAIL R1 reset: status=%h g=%b r=%b, expected 00/0/0", status, op_grant, op_reject);
    end
    // directed corners
    issue(4, 17'h00000, 0, 1, "R4 no latch");
    issue(1, 0, 0, 1, "R3 wren");
    issue(2, 0, 0, 1, "R3 wrdi");
    issue(3, 0, 8'hFF, 1, "R4 wrsr no latch");
    issue(1, 0, 0, 0, "R3 wren");
    issue(3, 0, 8'h04, 0, "R7 lock0 pin low");
    issue(1, 0, 0, 0, "R5 wren busy");
    issue(4, 17'h00010, 0, 0, "R5 busy refuse");
    issue(7, 0, 0, 1, "R5 done");
    issue(1, 0, 0, 1, "R3 wren");
    issue(4, 17'h17FFF, 0, 1, "R9 below quarter");
    issue(7, 0, 0, 1, "R5 done");
    issue(1, 0, 0, 1, "R3 wren");
    issue(5, 17'h18000, 0, 1, "R9 quarter edge");
    issue(1, 0, 0, 1, "R3 wren");
    issue(6, 0, 0, 1, "R10 bulk zone01");
    issue(1, 0, 0, 1, "R3 wren");
    issue(3, 0, 8'hFB, 1, "R2 wrsr mask lock1 zone10");
    issue(7, 0, 0, 1, "R5 done");
    issue(1, 0, 0, 1, "R6 wren");
    issue(4, 17'h10000, 0, 1, "R9 half edge");
    issue(1, 0, 0, 1, "R6 wren");
    issue(4, 17'h0FFFF, 0, 1, "R9 below half");
    issue(7, 0, 0, 0, "R8 pin lowered");
    issue(1, 0, 0, 0, "R8 wren");
    issue(3, 0, 8'h00, 0, "R8 frozen");
    issue(1, 0, 0, 1, "R8 wren");
    issue(3, 0, 8'h8C, 1, "R8 pin high lock1");
    issue(7, 0, 0, 1, "R5 done");
    issue(1, 0, 0, 1, "R9 wren");
    issue(4, 17'h00000, 0, 1, "R9 zone11 bottom");
    issue(1, 0, 0, 1, "R8 wren");
    issue(3, 0, 8'h00, 1, "R8 unlock pin high");
    issue(7, 0, 0, 0, "R5 done");
    issue(1, 0, 0, 0, "R8 wren");
    issue(3, 0, 8'h80, 0, "R8 set lock pin low");
    issue(7, 0, 0, 0, "R5 done");
    issue(1, 0, 0, 0, "R8 wren");
    issue(3, 0, 8'h00, 0, "R8 frozen other order");
    issue(1, 0, 0, 0, "R10 wren");
    issue(6, 0, 0, 0, "R10 bulk zone00");
    issue(7, 0, 0, 1, "R11 done");
    // random mix
    void'($urandom(32'h1234_5A5A));
    pin = 1;
    for (int i = 0; i < 3000; i++) begin
      r = $urandom % 16;
      if ($urandom % 8 == 0) pin = ~pin;
      a = 17'($urandom);
      if ($urandom % 4 == 0) a = {a[16:15], ($urandom % 2) ? 15'h7FFF : 15'h0000};
      if      (r < 5)  issue(1, a, 0, pin, "R3 rand");
      else if (r == 5) issue(2, a, 0, pin, "R3 rand");
      else if (r < 8)  issue(3, a, 8'($urandom), pin, "R8 rand");
      else if (r < 10) issue(4, a, 0, pin, "R9 rand");
      else if (r == 10) issue(5, a, 0, pin, "R9 rand");
      else if (r == 11) issue(6, a, 0, pin, "R10 rand");
      else if (r < 14) issue(7, a, 0, pin, "R5 rand");
      else             issue(0, a, 0, pin, "R11 rand");
    end
    summary();
  end
endmodule